// File: doc/BRIEF.md
# Parallel Port Output Latch

This block is a programmable parallel port with three ports of eight bits each. A host writes to it over a simple synchronous bus: a chip select, a write enable, a two-bit port address and a data byte. A control word sets the direction of each port. The two nibbles of the third port have separate direction bits. Every port that is set as an output drives its pins from a latch, and the pins stay at that value until a later write loads the latch again.

A write takes effect only when it ends. While chip select and write enable are both high, the block records the address and the data. In the first clock cycle after either of them drops, the recorded write is committed. The data goes into the addressed latch, but only the bits that are set as outputs are changed. A control write with its top bit clear does not change directions. It sets or clears one bit of the third port instead.

Reads are combinational. The read data follows the address input. Input bits return the live pins, output bits return the latch, and address 3 returns the current direction word.

Top module: `par_port_latch`

## Requirements
- R1: After reset, all three ports are inputs (every output enable is low), all latches are zero, and a read of address 3 returns 0x9B.
- R2: A write is active only in cycles where `chipSel` and `wrEn` are both high. A strobe with chip select low, or chip select with the strobe low, changes no latch.
- R3: A write is committed on the first clock edge at which it is no longer active. Latched outputs do not change while the write is held. A run of consecutive active cycles counts as one write, and the data from its last cycle is the data stored.
- R4: Port addresses are 0 = A, 1 = B, 2 = C, 3 = control. A data write to a port that is set as an input leaves that port's latch unchanged.
- R5: A control write with bit 7 set loads the directions, where a 1 means input: bit 4 is port A, bit 1 is port B, bit 3 is the upper nibble of C and bit 0 is the lower nibble of C. The word 0x82 makes A an output, B an input and C an output. Output enables go high exactly for the output bits.
- R6: A control write with bit 7 set clears every output latch to zero.
- R7: A control write with bit 7 clear changes one bit of the port C latch. Bits 3:1 select the bit and bit 0 is the new value. No other bit changes.
- R8: A write to port C updates only the nibbles that are set as outputs.
- R9: Reads of addresses 0 to 2 return the pin value for input bits and the latch value for output bits. A read of address 3 returns the direction word with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Chip select, active high |
| wrEn | input | 1 | Write strobe, active high |
| addr | input | 2 | Port address for writes and reads |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| portAIn | input | 8 | Port A pin levels |
| portBIn | input | 8 | Port B pin levels |
| portCIn | input | 8 | Port C pin levels |
| portAOut | output | 8 | Port A latch |
| portBOut | output | 8 | Port B latch |
| portCOut | output | 8 | Port C latch |
| portAOe | output | 8 | Port A per-bit output enable |
| portBOe | output | 8 | Port B per-bit output enable |
| portCOe | output | 8 | Port C per-bit output enable |

## Verification
The hardest case to reach is a write that is held for several cycles while its data changes. Here the latch has to stay at its old value throughout the hold, and then take the last data on the one edge after release. The stimulus holds the strobe over three edges and changes the data only in the final active cycle. It samples the output both before and after the release. Port C with mixed nibble directions is a second case that is easy to miss. It is reached by loading a direction word that splits C, then writing all ones and reading back a mix of pins and latch.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } portSel_e;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadC;
    logic loadMode;
    logic bitOp;
  } strobe_t;
endpackage

// File: rtl/ppl_ctrl.sv
module ppl_ctrl
  import ppl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         chipSel,
  input  logic         wrEn,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wrData,
  output strobe_t      strb,
  output logic [W-1:0] heldData
);
  logic         writing;
  logic         writingQ;
  logic [1:0]   addrQ;
  logic [W-1:0] dataQ;
  logic         commit;

  assign writing = chipSel & wrEn;

  // record the bus while the write is active; the last cycle wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      writingQ <= 1'b0;
      addrQ    <= '0;
      dataQ    <= '0;
    end else begin
      writingQ <= writing;
      if (writing) begin
        addrQ <= addr;
        dataQ <= wrData;
      end
    end
  end

  // trailing edge of the write
  assign commit = writingQ & ~writing;

  always_comb begin
    strb          = '0;
    strb.loadA    = commit && (addrQ == SEL_A);
    strb.loadB    = commit && (addrQ == SEL_B);
    strb.loadC    = commit && (addrQ == SEL_C);
    strb.loadMode = commit && (addrQ == SEL_CTRL) &&  dataQ[W-1];
    strb.bitOp    = commit && (addrQ == SEL_CTRL) && !dataQ[W-1];
  end

  assign heldData = dataQ;

  assert_one_command_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_commit_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|strb) |-> (!(chipSel && wrEn) && $past(chipSel && wrEn)));
endmodule

// File: rtl/ppl_datapath.sv
module ppl_datapath
  import ppl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] heldData,
  input  logic [1:0]   rdAddr,
  input  logic [W-1:0] pinA,
  input  logic [W-1:0] pinB,
  input  logic [W-1:0] pinC,
  output logic [W-1:0] outA,
  output logic [W-1:0] outB,
  output logic [W-1:0] outC,
  output logic [W-1:0] oeA,
  output logic [W-1:0] oeB,
  output logic [W-1:0] oeC,
  output logic [W-1:0] rdData
);
  localparam int HALF    = W / 2;
  localparam int IDXW    = $clog2(W);
  localparam int BIT_A   = 4;
  localparam int BIT_CHI = 3;
  localparam int BIT_B   = 1;
  localparam int BIT_CLO = 0;

  logic         dirAIn, dirBIn;
  logic [1:0]   dirCIn;   // [1] upper nibble, [0] lower nibble; 1 = input
  logic [W-1:0] latchA, latchB, latchC;
  logic [W-1:0] viewA, viewB, viewC;
  logic [W-1:0] modeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirAIn <= 1'b1;
      dirBIn <= 1'b1;
      dirCIn <= 2'b11;
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else if (strb.loadMode) begin
      dirAIn <= heldData[BIT_A];
      dirBIn <= heldData[BIT_B];
      dirCIn <= {heldData[BIT_CHI], heldData[BIT_CLO]};
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else begin
      if (strb.loadA && !dirAIn) latchA <= heldData;
      if (strb.loadB && !dirBIn) latchB <= heldData;
      if (strb.loadC) begin
        if (!dirCIn[0]) latchC[HALF-1:0] <= heldData[HALF-1:0];
        if (!dirCIn[1]) latchC[W-1:HALF] <= heldData[W-1:HALF];
      end
      if (strb.bitOp) latchC[heldData[IDXW:1]] <= heldData[0];
    end
  end

  assign outA = latchA;
  assign outB = latchB;
  assign outC = latchC;
  assign oeA  = {W{~dirAIn}};
  assign oeB  = {W{~dirBIn}};

  // port C nibbles have their own direction
  for (genvar h = 0; h < 2; h++) begin : g_cHalf
    assign oeC[h*HALF +: HALF]   = {HALF{~dirCIn[h]}};
    assign viewC[h*HALF +: HALF] = dirCIn[h] ? pinC[h*HALF +: HALF]
                                             : latchC[h*HALF +: HALF];
  end

  assign viewA = dirAIn ? pinA : latchA;
  assign viewB = dirBIn ? pinB : latchB;

  always_comb begin
    modeWord          = '0;
    modeWord[W-1]     = 1'b1;
    modeWord[BIT_A]   = dirAIn;
    modeWord[BIT_CHI] = dirCIn[1];
    modeWord[BIT_B]   = dirBIn;
    modeWord[BIT_CLO] = dirCIn[0];
  end

  always_comb begin
    unique case (rdAddr)
      2'd0:    rdData = viewA;
      2'd1:    rdData = viewB;
      2'd2:    rdData = viewC;
      default: rdData = modeWord;
    endcase
  end

  assert_mode_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMode |=> (latchA == '0 && latchB == '0 && latchC == '0));

  assert_input_a_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadA && dirAIn) |=> $stable(latchA));

  assert_input_b_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadB && dirBIn) |=> $stable(latchB));

  assert_hold_between_writes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(latchA) && $stable(latchB) && $stable(latchC)));

  assert_single_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitOp |=> ($countones(latchC ^ $past(latchC)) <= 1));

  assert_oe_follows_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadMode && !heldData[BIT_A]) |=> (oeA == '1));
endmodule

// File: rtl/par_port_latch.sv
module par_port_latch
  import ppl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         chipSel,
  input  logic         wrEn,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic [W-1:0] portAIn,
  input  logic [W-1:0] portBIn,
  input  logic [W-1:0] portCIn,
  output logic [W-1:0] portAOut,
  output logic [W-1:0] portBOut,
  output logic [W-1:0] portCOut,
  output logic [W-1:0] portAOe,
  output logic [W-1:0] portBOe,
  output logic [W-1:0] portCOe
);
  strobe_t      strb;
  logic [W-1:0] heldData;

  ppl_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strb     (strb),
    .heldData (heldData)
  );

  ppl_datapath #(.W(W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .heldData (heldData),
    .rdAddr   (addr),
    .pinA     (portAIn),
    .pinB     (portBIn),
    .pinC     (portCIn),
    .outA     (portAOut),
    .outB     (portBOut),
    .outC     (portCOut),
    .oeA      (portAOe),
    .oeB      (portBOe),
    .oeC      (portCOe),
    .rdData   (rdData)
  );
endmodule

// File: tb/par_port_latch_bench.sv
`timescale 1ns/1ps
module par_port_latch_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] portAIn = 8'h5A;
  logic [7:0] portBIn = 8'hC3;
  logic [7:0] portCIn = 8'h96;
  logic [7:0] portAOut, portBOut, portCOut;
  logic [7:0] portAOe, portBOe, portCOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  par_port_latch u_par_port_latch (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .portAIn(portAIn), .portBIn(portBIn),
    .portCIn(portCIn), .portAOut(portAOut), .portBOut(portBOut),
    .portCOut(portCOut), .portAOe(portAOe), .portBOe(portBOe), .portCOe(portCOe)
  );

  // {addr[37:36], data[35:28], expA[27:20], expB[19:12], expC[11:4], oeMask[3:0]}
  // oeMask bits: 3 = A, 2 = B, 1 = C upper nibble, 0 = C lower nibble
  localparam logic [37:0] VEC [14] = '{
    {2'd3, 8'h82, 8'h00, 8'h00, 8'h00, 4'b1011},  // R5 R6
    {2'd0, 8'h3C, 8'h3C, 8'h00, 8'h00, 4'b1011},  // R3
    {2'd1, 8'h77, 8'h3C, 8'h00, 8'h00, 4'b1011},  // R4
    {2'd2, 8'hA5, 8'h3C, 8'h00, 8'hA5, 4'b1011},  // R3
    {2'd3, 8'h07, 8'h3C, 8'h00, 8'hAD, 4'b1011},  // R7 set bit 3
    {2'd3, 8'h00, 8'h3C, 8'h00, 8'hAC, 4'b1011},  // R7 clear bit 0
    {2'd3, 8'h0E, 8'h3C, 8'h00, 8'h2C, 4'b1011},  // R7 clear bit 7
    {2'd3, 8'h89, 8'h00, 8'h00, 8'h00, 4'b1100},  // R5 R6
    {2'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 4'b1100},  // R8 both nibbles input
    {2'd3, 8'h88, 8'h00, 8'h00, 8'h00, 4'b1101},  // R5
    {2'd2, 8'hFF, 8'h00, 8'h00, 8'h0F, 4'b1101},  // R8 lower nibble only
    {2'd1, 8'h81, 8'h00, 8'h81, 8'h0F, 4'b1101},  // R4 B is output
    {2'd3, 8'h92, 8'h00, 8'h00, 8'h00, 4'b0011},  // R5 R6
    {2'd0, 8'h11, 8'h00, 8'h00, 8'h00, 4'b0011}   // R4 A is input
  };

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    @(negedge clk);
    chipSel = 1'b0; wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic readAt(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    doReset();

    // R1 reset state
    check8("R1", "oeA", portAOe, 8'h00);
    check8("R1", "oeC", portCOe, 8'h00);
    check8("R1", "outB", portBOut, 8'h00);
    readAt(2'd3, rv); check8("R1", "mode read", rv, 8'h9B);
    readAt(2'd0, rv); check8("R9", "input A read", rv, 8'h5A);

    // vector table
    for (int i = 0; i < 14; i++) begin
      logic [37:0] v;
      logic [7:0]  expOeC;
      v = VEC[i];
      busWrite(v[37:36], v[35:28]);
      expOeC = {{4{v[1]}}, {4{v[0]}}};
      check8("R3..R8 table", "outA", portAOut, v[27:20]);
      check8("R3..R8 table", "outB", portBOut, v[19:12]);
      check8("R3..R8 table", "outC", portCOut, v[11:4]);
      check8("R5 table", "oeA", portAOe, {8{v[3]}});
      check8("R5 table", "oeB", portBOe, {8{v[2]}});
      check8("R5 table", "oeC", portCOe, expOeC);
    end

    // R2: incomplete write qualifiers
    busWrite(2'd3, 8'h82);
    @(negedge clk); chipSel = 1'b0; wrEn = 1'b1; addr = 2'd0; wrData = 8'h99;
    repeat (2) @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    check8("R2", "strobe without select", portAOut, 8'h00);
    @(negedge clk); chipSel = 1'b1; wrEn = 1'b0; wrData = 8'h99;
    repeat (2) @(negedge clk); chipSel = 1'b0;
    @(negedge clk);
    check8("R2", "select without strobe", portAOut, 8'h00);

    // R3: held write, data changes in the last active cycle
    @(negedge clk); chipSel = 1'b1; wrEn = 1'b1; addr = 2'd0; wrData = 8'h44;
    @(negedge clk);
    @(negedge clk); wrData = 8'h55;
    @(negedge clk);
    check8("R3", "held write not yet applied", portAOut, 8'h00);
    chipSel = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    check8("R3", "last data latched after release", portAOut, 8'h55);

    // R9 readback under 0x82
    readAt(2'd0, rv); check8("R9", "A latch read", rv, 8'h55);
    readAt(2'd1, rv); check8("R9", "B pin read", rv, 8'hC3);
    readAt(2'd2, rv); check8("R9", "C latch read", rv, 8'h00);
    readAt(2'd3, rv); check8("R9", "mode read", rv, 8'h82);

    // R8 R9: split port C
    busWrite(2'd3, 8'h88);
    busWrite(2'd2, 8'hFF);
    readAt(2'd2, rv); check8("R9", "C mixed read", rv, 8'h9F);
    check8("R8", "C mixed latch", portCOut, 8'h0F);

    // R1: reset after activity
    doReset();
    check8("R1", "oeA after reset", portAOe, 8'h00);
    check8("R1", "outC after reset", portCOut, 8'h00);
    readAt(2'd3, rv); check8("R1", "mode after reset", rv, 8'h9B);
    readAt(2'd0, rv); check8("R1", "A pins after reset", rv, 8'h5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule